// File: doc/BRIEF.md
# Bus-Master Access Protection Checker

This block sits in the path of one external bus master and decides, for every request, whether it may proceed. A small table of protection regions lives in configuration registers. Each region pairs a word-granular address field with a mode byte. The mode byte carries read, write and execute grants, an address-matching selector and a lock bit. A region in power-of-two mode covers an aligned block. Its size is taken from the number of trailing ones in its address field.

Each request gives an address, an access kind and a transaction ID. The block answers one clock later with allow or deny. The first denied request is captured into a sticky fail record, which holds the address, the direction, the ID and a failed flag. Reading that record leaves it unchanged. Only a dedicated clear input drops the flag.

Configuration and the fail record share a 256-byte register window. It is reached through a plain write strobe and a combinational read port.

Top module: `mprot_checker`

## Requirements
- R1: After reset every region entry reads as zero (matching off, no grants, unlocked), the fail record reads as zero and `resp_valid` is low.
- R2: Region entry i sits at byte offset 8*i of the window, where i is `cfg_addr[7:3]` and `cfg_addr[2:0]` is ignored. Its word holds the address field in bits [37:0] and the mode byte in bits [63:56]. Bits [55:38] always read as zero, whatever was written to them.
- R3: Slots whose index is at or above `NUM_REGIONS`, and byte offsets above the fail record, read as zero and ignore writes.
- R4: Mode byte bit 0 grants read, bit 1 grants write and bit 2 grants execute. Bits [4:3] select matching: 3 is the power-of-two mode and any other value disables the region. `acc_kind` is 0 for read, 1 for write and 2 for execute. Kind 3 is always denied.
- R5: A power-of-two region whose address field ends in t ones covers 2^(t+1) words (2^(t+3) bytes), aligned to that size. The region is the one that holds the field's address with those low bits cleared. A field of all ones covers the whole space.
- R6: When several enabled regions match, the lowest-numbered one alone decides the outcome. A request that matches no enabled region is denied.
- R7: `resp_valid` is high exactly in the cycle after a cycle with `acc_valid` high. `resp_allow` is high only together with `resp_valid`. A configuration write takes effect for requests presented from the next cycle on.
- R8: Writing a 1 to mode byte bit 7 (word bit 63) locks the entry. Later writes to it are ignored until reset, while its matching continues.
- R9: The first denied request, made while the flag is clear, is recorded in the fail record at byte offset 0x80. The record holds the address in bits [37:0], bit 38 = 1 for a write and 0 for a read or execute, the ID in bits [42:39], the flag in bit 43, and zero above. While the flag is set, later denials leave the record unchanged.
- R10: Reading the fail record does not clear it, and writes to it are ignored. `fail_clear` drops the flag in the next cycle and keeps the other fields. If a denial arrives in the same cycle as the clear, the clear wins and that denial is not recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 8 | Byte offset into the register window |
| cfg_wr_en | input | 1 | Write strobe for the register window |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Read data for `cfg_addr` (combinational) |
| acc_valid | input | 1 | A request is presented this cycle |
| acc_addr | input | 38 | Word address of the request |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| acc_id | input | 4 | Transaction ID of the request |
| fail_clear | input | 1 | Clears the sticky failed flag |
| resp_valid | output | 1 | Verdict for the previous cycle's request |
| resp_allow | output | 1 | 1 = allowed, 0 = denied |

## Verification
Any corrupted region entry appears on `cfg_rdata` as soon as that slot is addressed. It also changes the next verdict for an address near the region's edge. The bench therefore compares the read port and the verdict against a behavioural model every cycle. A fail record that is captured wrongly, overwritten or not cleared shows in the status word one cycle after the offending request or clear. A priority or mask fault shows only on requests that overlap regions or sit on a region boundary. That is why the stimulus targets those addresses.

// File: rtl/mprot_pkg.sv
package mprot_pkg;
  // mode byte bit positions
  localparam int MB_RD   = 0;
  localparam int MB_WR   = 1;
  localparam int MB_EX   = 2;
  localparam int MB_AM   = 3;  // two bits [4:3]
  localparam int MB_LOCK = 7;
  localparam logic [1:0] AM_POW2 = 2'b11;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_EXEC  = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/mprot_region.sv
module mprot_region
  import mprot_pkg::*;
#(
  parameter int ADDR_W = 38,
  parameter int MODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_kind,
  output logic [ADDR_W-1:0] ent_addr,
  output logic [MODE_W-1:0] ent_mode,
  output logic              locked,
  output logic              hit,
  output logic              perm_ok
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              upd_en;
  logic [ADDR_W-1:0] care_mask;

  assign upd_en = wr_en & ~mode_q[MB_LOCK];

  always_comb begin
    addr_d = wr_addr;
    mode_d = wr_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mode_q <= '0;
    end else if (upd_en) begin
      addr_q <= addr_d;
      mode_q <= mode_d;
    end
  end

  // trailing ones plus the first zero are don't-care bits
  assign care_mask = ~(addr_q ^ (addr_q + ADDR_W'(1)));

  always_comb begin
    hit = (mode_q[MB_AM+1:MB_AM] == AM_POW2) &&
          (((acc_addr ^ addr_q) & care_mask) == '0);
    unique case (acc_kind)
      KIND_READ:  perm_ok = mode_q[MB_RD];
      KIND_WRITE: perm_ok = mode_q[MB_WR];
      KIND_EXEC:  perm_ok = mode_q[MB_EX];
      default:    perm_ok = 1'b0;
    endcase
  end

  assign ent_addr = addr_q;
  assign ent_mode = mode_q;
  assign locked   = mode_q[MB_LOCK];
endmodule

// File: rtl/mprot_prio.sv
module mprot_prio #(
  parameter int N = 8
) (
  input  logic [N-1:0] hit,
  input  logic [N-1:0] perm_ok,
  output logic         allow
);
  always_comb begin
    allow = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) allow = perm_ok[i];
    end
  end
endmodule

// File: rtl/mprot_fail.sv
module mprot_fail #(
  parameter int ADDR_W = 38,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deny_evt,
  input  logic              clear,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic              evt_write,
  input  logic [ID_W-1:0]   evt_id,
  output logic              flag,
  output logic [ADDR_W-1:0] rec_addr,
  output logic              rec_write,
  output logic [ID_W-1:0]   rec_id
);
  logic flag_q, flag_d, cap_en;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [ID_W-1:0]   id_q;

  always_comb begin
    cap_en = deny_evt & ~flag_q & ~clear;
    flag_d = flag_q;
    if (clear)       flag_d = 1'b0;
    else if (cap_en) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wr_q   <= 1'b0;
      id_q   <= '0;
    end else if (cap_en) begin
      addr_q <= evt_addr;
      wr_q   <= evt_write;
      id_q   <= evt_id;
    end
  end

  assign flag      = flag_q;
  assign rec_addr  = addr_q;
  assign rec_write = wr_q;
  assign rec_id    = id_q;
endmodule

// File: rtl/mprot_checker.sv
module mprot_checker
  import mprot_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 38,
  parameter int ID_W        = 4,
  parameter int WORD_W      = 64,
  parameter int WIN_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIN_W-1:0]  cfg_addr,
  input  logic              cfg_wr_en,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_kind,
  input  logic [ID_W-1:0]   acc_id,
  input  logic              fail_clear,
  output logic              resp_valid,
  output logic              resp_allow
);
  localparam int MODE_W      = 8;
  localparam int RSV_W       = WORD_W - MODE_W - ADDR_W;
  localparam int STAT_PAD_W  = WORD_W - ADDR_W - ID_W - 2;
  localparam int SLOT_W      = WIN_W - 3;
  localparam int MAX_REGIONS = 16;
  localparam int STATUS_SLOT = MAX_REGIONS;

  logic [SLOT_W-1:0]          slot;
  logic [NUM_REGIONS-1:0]     wr_sel, hit_vec, ok_vec, lock_vec;
  logic [NUM_REGIONS*WORD_W-1:0] ent_flat;
  logic                       allow_c, deny_evt;
  logic                       rv_q, ra_q, ra_d;
  logic                       fail_flag, fail_wr;
  logic [ADDR_W-1:0]          fail_addr;
  logic [ID_W-1:0]            fail_id;
  logic [WORD_W-1:0]          fail_word;
  logic                       unused_bits;

  assign slot        = cfg_addr[WIN_W-1:3];
  assign unused_bits = ^{cfg_addr[2:0], cfg_wdata[WORD_W-MODE_W-1:ADDR_W]};

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_reg
    logic [ADDR_W-1:0] e_addr;
    logic [MODE_W-1:0] e_mode;
    assign wr_sel[g] = cfg_wr_en && (slot == SLOT_W'(g));
    mprot_region #(.ADDR_W(ADDR_W), .MODE_W(MODE_W)) u_region (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_sel[g]),
      .wr_addr  (cfg_wdata[ADDR_W-1:0]),
      .wr_mode  (cfg_wdata[WORD_W-1 -: MODE_W]),
      .acc_addr (acc_addr),
      .acc_kind (acc_kind),
      .ent_addr (e_addr),
      .ent_mode (e_mode),
      .locked   (lock_vec[g]),
      .hit      (hit_vec[g]),
      .perm_ok  (ok_vec[g])
    );
    assign ent_flat[g*WORD_W +: WORD_W] = {e_mode, {RSV_W{1'b0}}, e_addr};
  end

  mprot_prio #(.N(NUM_REGIONS)) u_prio (
    .hit     (hit_vec),
    .perm_ok (ok_vec),
    .allow   (allow_c)
  );

  assign deny_evt = acc_valid & ~allow_c;

  mprot_fail #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_fail (
    .clk       (clk),
    .rst_n     (rst_n),
    .deny_evt  (deny_evt),
    .clear     (fail_clear),
    .evt_addr  (acc_addr),
    .evt_write (acc_kind == KIND_WRITE),
    .evt_id    (acc_id),
    .flag      (fail_flag),
    .rec_addr  (fail_addr),
    .rec_write (fail_wr),
    .rec_id    (fail_id)
  );

  assign fail_word = {{STAT_PAD_W{1'b0}}, fail_flag, fail_id, fail_wr, fail_addr};

  assign ra_d = acc_valid & allow_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      ra_q <= 1'b0;
    end else begin
      rv_q <= acc_valid;
      ra_q <= ra_d;
    end
  end

  assign resp_valid = rv_q;
  assign resp_allow = ra_q;

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (slot == SLOT_W'(i)) cfg_rdata = ent_flat[i*WORD_W +: WORD_W];
    end
    if (slot == SLOT_W'(STATUS_SLOT)) cfg_rdata = fail_word;
  end
endmodule

module mprot_checker_sva #(
  parameter int N      = 8,
  parameter int WORD_W = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                acc_valid,
  input logic                fail_clear,
  input logic                resp_valid,
  input logic                resp_allow,
  input logic                fail_flag,
  input logic [WORD_W-1:0]   fail_word,
  input logic [N-1:0]        lock_vec,
  input logic [N*WORD_W-1:0] ent_flat
);
  a_r7_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> resp_valid);
  a_r7_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !resp_valid);
  a_r7_allow_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    resp_allow |-> resp_valid);
  a_r9_deny_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_allow) |-> (fail_flag || $past(fail_clear)));
  a_r9_flag_rise_on_deny: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_flag) |-> (resp_valid && !resp_allow));
  a_r9_record_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_flag && !fail_clear) |=> (fail_flag && $stable(fail_word)));
  a_r10_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    fail_clear |=> !fail_flag);

  for (genvar g = 0; g < N; g++) begin : g_lock
    a_r8_locked_entry_stable: assert property (@(posedge clk) disable iff (!rst_n)
      lock_vec[g] |=> $stable(ent_flat[g*WORD_W +: WORD_W]));
  end
endmodule

bind mprot_checker mprot_checker_sva #(.N(NUM_REGIONS), .WORD_W(WORD_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .fail_clear (fail_clear),
  .resp_valid (resp_valid),
  .resp_allow (resp_allow),
  .fail_flag  (fail_flag),
  .fail_word  (fail_word),
  .lock_vec   (lock_vec),
  .ent_flat   (ent_flat)
);

// File: tb/test_mprot_checker.sv
module test_mprot_checker;
  localparam int CLK_P = 10;
  localparam int NR    = 4;
  localparam int AW    = 38;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic        cfg_wr_en = 1'b0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic        acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0]  acc_kind = '0;
  logic [3:0]  acc_id = '0;
  logic        fail_clear = 1'b0;
  logic        resp_valid, resp_allow;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  mprot_checker #(.NUM_REGIONS(NR)) i_mprot_checker (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr_en(cfg_wr_en),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_id(acc_id),
    .fail_clear(fail_clear), .resp_valid(resp_valid), .resp_allow(resp_allow)
  );

  // ---------------- behavioural reference model ----------------
  logic [63:0] m_ent [16];
  logic        m_flag, m_fdir, m_rv, m_ra;
  logic [AW-1:0] m_faddr;
  logic [3:0]  m_fid;

  function automatic logic m_covers(logic [AW-1:0] field, logic [AW-1:0] a);
    int t = 0;
    while (t < AW && field[t]) t++;
    if (t + 1 >= AW) return 1'b1;
    return (a >> (t + 1)) == (field >> (t + 1));
  endfunction

  function automatic logic m_decide(logic [AW-1:0] a, logic [1:0] k);
    for (int i = 0; i < NR; i++) begin
      logic [7:0] md = m_ent[i][63:56];
      if (md[4:3] == 2'b11 && m_covers(m_ent[i][AW-1:0], a)) begin
        if (k == 2'd3) return 1'b0;
        return md[k];
      end
    end
    return 1'b0;
  endfunction

  function automatic logic [63:0] m_read(logic [7:0] a);
    int idx = int'(a[7:3]);
    if (idx < NR) return m_ent[idx];
    if (idx == 16) return {20'b0, m_flag, m_fid, m_fdir, m_faddr};
    return 64'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_ent[i] = '0;
      m_flag = 0; m_fdir = 0; m_faddr = '0; m_fid = '0; m_rv = 0; m_ra = 0;
    end else begin
      logic dec;
      int widx;
      dec  = m_decide(acc_addr, acc_kind);
      m_rv = acc_valid;
      m_ra = acc_valid && dec;
      if (fail_clear) m_flag = 0;
      else if (acc_valid && !dec && !m_flag) begin
        m_flag = 1; m_faddr = acc_addr; m_fdir = (acc_kind == 2'd1); m_fid = acc_id;
      end
      widx = int'(cfg_addr[7:3]);
      if (cfg_wr_en && widx < NR && !m_ent[widx][63])
        m_ent[widx] = {cfg_wdata[63:56], 18'b0, cfg_wdata[AW-1:0]};
    end
  end

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison, a quarter period after the edge (R7, R2)
  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n) begin
      check64("R7 resp_valid vs model", 64'(resp_valid), 64'(m_rv));
      check64("R7 resp_allow vs model", 64'(resp_allow), 64'(m_ra));
      check64("R2 cfg_rdata vs model", cfg_rdata, m_read(cfg_addr));
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic wr(logic [7:0] a, logic [63:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_wr_en = 1'b1;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [63:0] exp, string tag);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check64(tag, cfg_rdata, exp);
  endtask

  task automatic acc(logic [1:0] k, logic [AW-1:0] a, logic [3:0] id,
                     logic clr, logic exp, string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_kind = k; acc_addr = a; acc_id = id; fail_clear = clr;
    @(negedge clk);
    acc_valid = 1'b0; fail_clear = 1'b0;
    check64(tag, {62'b0, resp_valid, resp_allow}, {62'b0, 1'b1, exp});
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    fail_clear = 1'b1;
    @(negedge clk);
    fail_clear = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check64("R1 resp_valid after reset", 64'(resp_valid), 64'h0);
    rd(8'h00, 64'h0, "R1 entry0 reset");
    rd(8'h80, 64'h0, "R1 fail record reset");

    // R2 layout, reserved bits dropped; region 0: words 0x100..0x10F, read only
    wr(8'h00, {8'h19, 18'h3FFFF, 38'h107});
    rd(8'h03, 64'h1900_0000_0000_0107, "R2 entry0 readback");

    // R5 boundaries
    acc(2'd0, 38'h100, 4'd1, 1'b0, 1'b1, "R5 lowest word inside");
    acc(2'd0, 38'h10F, 4'd2, 1'b0, 1'b1, "R5 highest word inside");
    acc(2'd0, 38'h0FF, 4'd3, 1'b0, 1'b0, "R5 just below region");
    rd(8'h80, 64'h0000_0980_0000_00FF, "R9 first denial captured");
    acc(2'd0, 38'h110, 4'd4, 1'b0, 1'b0, "R5 just above region");
    acc(2'd1, 38'h105, 4'd5, 1'b0, 1'b0, "R4 write without grant");
    acc(2'd2, 38'h105, 4'd6, 1'b0, 1'b0, "R4 exec without grant");
    rd(8'h80, 64'h0000_0980_0000_00FF, "R9 later denials keep record");
    rd(8'h80, 64'h0000_0980_0000_00FF, "R10 read does not clear");

    // R10 clear behaviour
    pulse_clear();
    rd(8'h80, 64'h0000_0180_0000_00FF, "R10 clear drops flag only");
    acc(2'd1, 38'h105, 4'd7, 1'b1, 1'b0, "R10 denial during clear");
    rd(8'h80, 64'h0000_0180_0000_00FF, "R10 clear wins same cycle");
    acc(2'd1, 38'h200, 4'd9, 1'b0, 1'b0, "R6 no region matches");
    rd(8'h80, 64'h0000_0CC0_0000_0200, "R9 write denial recorded");
    wr(8'h80, 64'h0);
    rd(8'h80, 64'h0000_0CC0_0000_0200, "R10 status write ignored");

    // R6 priority: entry1 covers everything with RWX
    wr(8'h08, {8'h1F, 18'h0, 38'h3F_FFFF_FFFF});
    acc(2'd1, 38'h105, 4'd1, 1'b0, 1'b0, "R6 lower index decides");
    acc(2'd1, 38'h500, 4'd2, 1'b0, 1'b1, "R6 higher index allows");
    wr(8'h08, {8'h07, 18'h0, 38'h3F_FFFF_FFFF});
    acc(2'd1, 38'h500, 4'd3, 1'b0, 1'b0, "R4 matching mode 0 disabled");
    wr(8'h08, {8'h0F, 18'h0, 38'h3F_FFFF_FFFF});
    acc(2'd1, 38'h500, 4'd4, 1'b0, 1'b0, "R4 matching mode 1 disabled");
    acc(2'd3, 38'h100, 4'd5, 1'b0, 1'b0, "R4 kind 3 denied");
    acc(2'd0, 38'h100, 4'd6, 1'b0, 1'b1, "R4 read granted");

    // R8 lock: entry2 words 0x400..0x403, RW, locked
    wr(8'h10, {8'h9B, 18'h0, 38'h401});
    wr(8'h10, 64'h0);
    rd(8'h10, 64'h9B00_0000_0000_0401, "R8 locked entry unchanged");
    acc(2'd1, 38'h403, 4'd7, 1'b0, 1'b1, "R8 locked entry still matches");
    acc(2'd2, 38'h402, 4'd8, 1'b0, 1'b0, "R8 locked entry no exec");

    // R3 absent slots
    wr(8'h20, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(8'h20, 64'h0, "R3 slot 4 absent");
    wr(8'h78, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(8'h78, 64'h0, "R3 slot 15 absent");
    rd(8'h88, 64'h0, "R3 beyond status");

    pulse_clear();
    rd(8'h80, 64'h0000_04C0_0000_0200, "R10 final clear");

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule